// File: doc/BRIEF.md
# Counter-Compare Watchdog Timer

This block is a watchdog built on one compare channel of a free-running 16-bit counter. The channel keeps two bytes. The high byte is a deadline, compared against the upper byte of the counter. The low byte is an offset. When the upper byte of the counter steps onto the deadline, the block emits a one-cycle reset request.

Software keeps the system alive by writing any value to the deadline byte. Each such write sets a new deadline equal to the current upper counter byte plus the offset, with the 8-bit sum wrapping. The counter advances on a prescaled count-enable input.

The watchdog is active out of reset. While it is active, the counter is forced to run. The same state freezes the counter value, the clock-select and idle-control fields, and the channel mode register against writes. Clearing the enable bit releases all of these locks at once.

The block sits on a simple register bus with a write strobe, a read strobe and a 3-bit address. Read data is registered and appears one cycle after the read strobe.

Top module: `cwd_top`

## Requirements
- R1: After reset the watchdog enable (bit 7 of the mode register, address 1) reads 1. The run bit (address 0, bit 0) reads 0. Counter bytes (addresses 2 low, 3 high) read 0. The deadline byte (address 6) reads 0.
- R2: While enabled, a step of the upper counter byte onto the deadline value raises `wdog_rst` in the following cycle.
- R3: The offset byte (address 5) is read/write and holds its value.
- R4: While enabled, a write of any data to address 6 loads the deadline with (upper counter byte + offset) mod 256.
- R5: While enabled, the counter advances on every `cnt_tick` even when the software run bit is 0.
- R6: The run bit reads back only what software wrote to it, so it reads 0 while enabled if software never set it.
- R7: While enabled, writes to the counter bytes are ignored, and the clock-select (mode bits 3:1) and idle (mode bit 0) fields keep their values.
- R8: While enabled, writes to the channel mode register (address 4) are blocked, and it reads as the software-timer code 0x48.
- R9: Each match event gives exactly one `wdog_rst` pulse, one clock cycle long.
- R10: Clearing the enable bit suppresses a match in the same cycle and every match after it. It also releases the write locks. While disabled, the counter advances only when the run bit is 1, and a write to address 6 stores the written data.
- R11: A refresh write issued in the same cycle as a match wins, and no reset is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Prescaled counter advance enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| wdog_rst | output | 1 | One-cycle reset request |

## Verification
The timeout path is exercised with a counter preset just below a byte boundary and an offset of 2. This separates a reset on the exact tick that moves the upper byte onto the deadline from a reset that comes one tick early or late.

A refresh with a large offset checks that the deadline sum wraps. A refresh landing on the match tick, and a disable landing on the match tick, separate the cases where the write takes priority from the cases where it is applied too late.

Locked and unlocked writes to the counter, the mode fields and the channel mode register are compared through read-back. This shows that each lock depends on the enable bit alone.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = CNT_W / 2;
    localparam int ADDR_W = 3;

    // Register map as seen on the bus
    localparam logic [ADDR_W-1:0] A_RUN    = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CHMODE = 3'd4;
    localparam logic [ADDR_W-1:0] A_OFFSET = 3'd5;
    localparam logic [ADDR_W-1:0] A_DEADLN = 3'd6;

    // Code read from the channel mode register while the watchdog owns it
    localparam logic [BYTE_W-1:0] SWTIMER_CODE = 8'h48;
    localparam int EN_BIT = 7;
endpackage

// File: rtl/cwd_counter.sv
// Free-running counter with write lock.
// Assumes: CNT_W is even; the lock and force inputs come from registered state.
module cwd_counter #(
    parameter int CNT_W = 16,
    localparam int BW = CNT_W / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run_sw,
    input  logic          wd_on,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [BW-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic          hi_step,
    output logic [BW-1:0] hi_next
);
    logic adv;

    // Advance condition: software run or forced by watchdog
    always_comb begin
        adv     = tick && (run_sw || wd_on);
        hi_step = adv && (cnt[BW-1:0] == {BW{1'b1}});
        hi_next = cnt[CNT_W-1:BW] + 1'b1;
    end

    // Counter state: bus write when unlocked, else advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!wd_on && (wr_lo || wr_hi)) begin
            if (wr_lo) cnt[BW-1:0]     <= wdata;
            if (wr_hi) cnt[CNT_W-1:BW] <= wdata;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7
    locked_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_on && !tick && (wr_lo || wr_hi)) |=> $stable(cnt));
    // R5
    forced_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_on && tick) |=> (cnt != $past(cnt)));
endmodule

// File: rtl/cwd_cfg.sv
// Configuration registers: run bit, mode (enable, clock select, idle),
// channel mode and offset. Assumes one bus write per cycle.
module cwd_cfg #(
    parameter int BW = 8,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] wdata,
    output logic          run_sw,
    output logic          wd_on,
    output logic          wd_live,
    output logic [2:0]    clksel,
    output logic          idle_hold,
    output logic [BW-1:0] ch_mode,
    output logic [BW-1:0] offset
);
    import cwd_pkg::*;

    logic wr_mode;

    // Decode of the mode write and the match gate
    always_comb begin
        wr_mode = wr_en && (addr == A_MODE);
        wd_live = wd_on && !(wr_mode && !wdata[EN_BIT]);
    end

    // Register updates with lock on clock select, idle and channel mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_sw    <= 1'b0;
            wd_on     <= 1'b1;
            clksel    <= '0;
            idle_hold <= 1'b0;
            ch_mode   <= '0;
            offset    <= '0;
        end else if (wr_en) begin
            case (addr)
                A_RUN:  run_sw <= wdata[0];
                A_MODE: begin
                    wd_on <= wdata[EN_BIT];
                    if (!wd_on) begin
                        clksel    <= wdata[3:1];
                        idle_hold <= wdata[0];
                    end
                end
                A_CHMODE: if (!wd_on) ch_mode <= wdata;
                A_OFFSET: offset <= wdata;
                default: ;
            endcase
        end
    end

    // R8
    chmode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_on |=> $stable(ch_mode));
    // R7
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_on |=> ($stable(clksel) && $stable(idle_hold)));
endmodule

// File: rtl/cwd_match.sv
// Deadline register, refresh and match detector. Assumes hi_step/hi_next
// describe the counter's upper byte on the coming edge.
module cwd_match #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wd_on,
    input  logic          wd_live,
    input  logic          wr_dl,
    input  logic [BW-1:0] wdata,
    input  logic [BW-1:0] cnt_hi,
    input  logic [BW-1:0] offset,
    input  logic          hi_step,
    input  logic [BW-1:0] hi_next,
    output logic [BW-1:0] deadline,
    output logic          wdog_rst
);
    logic refresh;
    logic hit;

    // Refresh strobe and match event
    always_comb begin
        refresh = wr_dl && wd_on;
        hit     = wd_live && hi_step && (hi_next == deadline) && !refresh;
    end

    // Deadline: reload on refresh, plain store when disabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            deadline <= '0;
        else if (refresh)
            deadline <= cnt_hi + offset;
        else if (wr_dl)
            deadline <= wdata;
    end

    // Registered one-cycle reset request
    always_ff @(posedge clk) begin
        if (!rst_n) wdog_rst <= 1'b0;
        else        wdog_rst <= hit;
    end

    // R9
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst);
    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_live |=> !wdog_rst);
    // R11
    refresh_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> !wdog_rst);
    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (deadline == $past(cnt_hi + offset)));
endmodule

// File: rtl/cwd_top.sv
// Counter-compare watchdog top: wires counter, configuration and match
// logic, decodes bus writes and registers read data.
module cwd_top #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    localparam int BW = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BW-1:0]     wdata,
    output logic [BW-1:0]     rdata,
    output logic              wdog_rst
);
    import cwd_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic             hi_step, run_sw, wd_on, wd_live, idle_hold;
    logic [BW-1:0]    hi_next, ch_mode, offset, deadline;
    logic [2:0]       clksel;
    logic             wr_lo, wr_hi, wr_dl;

    // Write strobes per target
    always_comb begin
        wr_lo = wr_en && (addr == A_CNT_LO);
        wr_hi = wr_en && (addr == A_CNT_HI);
        wr_dl = wr_en && (addr == A_DEADLN);
    end

    cwd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .run_sw(run_sw),
        .wd_on(wd_on), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata),
        .cnt(cnt), .hi_step(hi_step), .hi_next(hi_next)
    );

    cwd_cfg #(.BW(BW), .AW(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .run_sw(run_sw), .wd_on(wd_on), .wd_live(wd_live), .clksel(clksel),
        .idle_hold(idle_hold), .ch_mode(ch_mode), .offset(offset)
    );

    cwd_match #(.BW(BW)) u_match (
        .clk(clk), .rst_n(rst_n), .wd_on(wd_on), .wd_live(wd_live),
        .wr_dl(wr_dl), .wdata(wdata), .cnt_hi(cnt[CNT_W-1:BW]),
        .offset(offset), .hi_step(hi_step), .hi_next(hi_next),
        .deadline(deadline), .wdog_rst(wdog_rst)
    );

    // Registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                A_RUN:    rdata <= {{(BW-1){1'b0}}, run_sw};
                A_MODE:   rdata <= {wd_on, 3'b000, clksel, idle_hold};
                A_CNT_LO: rdata <= cnt[BW-1:0];
                A_CNT_HI: rdata <= cnt[CNT_W-1:BW];
                A_CHMODE: rdata <= wd_on ? SWTIMER_CODE : ch_mode;
                A_OFFSET: rdata <= offset;
                A_DEADLN: rdata <= deadline;
                default:  rdata <= '0;
            endcase
        end
    end
endmodule

// File: tb/cwd_top_bench.sv
module cwd_top_bench;
    logic clk = 1'b0, rst_n = 1'b0, cnt_tick = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic wdog_rst;

    int checks = 0, fails = 0, rst_cnt = 0, long_pulse = 0;
    logic prev_rst = 1'b0, rd_seen = 1'b0, done = 1'b0;

    typedef struct { logic [7:0] exp; string req; } item_t;
    item_t exp_q[$];

    always #5 clk = ~clk;

    cwd_top u_cwd_top (.clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wdog_rst(wdog_rst));

    // Pulse counter and pulse-length monitor
    always @(posedge clk) begin
        rd_seen  <= rd_en;
        prev_rst <= rst_n && wdog_rst;
        if (rst_n && wdog_rst) rst_cnt <= rst_cnt + 1;
        if (rst_n && wdog_rst && prev_rst) long_pulse <= long_pulse + 1;
    end

    // Scoreboard monitor: pops expected read data
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (rdata !== it.exp) begin
                fails++;
                $display("FAIL %s: rdata=%h expected=%h", it.req, rdata, it.exp);
            end
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string req);
        item_t it;
        it.exp = e; it.req = req;
        exp_q.push_back(it);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic tk);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; cnt_tick = tk;
        @(negedge clk); wr_en = 1'b0; cnt_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); cnt_tick = 1'b1;
        repeat (n) @(negedge clk);
        cnt_tick = 1'b0;
    endtask

    // Disable, preset counter, re-enable
    task automatic preset(input logic [7:0] hi, input logic [7:0] lo);
        wr(3'd1, 8'h00, 1'b0);
        wr(3'd2, lo, 1'b0);
        wr(3'd3, hi, 1'b0);
        wr(3'd1, 8'h80, 1'b0);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd1, 8'h80, "R1");
        rd(3'd0, 8'h00, "R1");
        rd(3'd3, 8'h00, "R1");
        rd(3'd6, 8'h00, "R1");
        // R5 forced run, R6 run bit reads 0
        ticks(5);
        rd(3'd2, 8'h05, "R5");
        rd(3'd0, 8'h00, "R6");
        wr(3'd0, 8'h01, 1'b0);
        rd(3'd0, 8'h01, "R6");
        wr(3'd0, 8'h00, 1'b0);
        // R7 locks
        wr(3'd2, 8'hAA, 1'b0);
        wr(3'd3, 8'hBB, 1'b0);
        rd(3'd2, 8'h05, "R7");
        rd(3'd3, 8'h00, "R7");
        wr(3'd1, 8'h8F, 1'b0);
        rd(3'd1, 8'h80, "R7");
        // R8 channel mode lock
        wr(3'd4, 8'h11, 1'b0);
        rd(3'd4, 8'h48, "R8");
        // R3 offset, R4 refresh and timeout, R2/R9
        preset(8'h10, 8'hF0);
        wr(3'd5, 8'h02, 1'b0);
        rd(3'd5, 8'h02, "R3");
        wr(3'd6, 8'h5A, 1'b0);
        rd(3'd6, 8'h12, "R4");
        base = rst_cnt;
        ticks(271);
        repeat (3) @(negedge clk);
        chk(rst_cnt == base, "R2 early", rst_cnt - base, 0);
        ticks(1);
        repeat (3) @(negedge clk);
        chk(rst_cnt == base + 1, "R2", rst_cnt - base, 1);
        chk(long_pulse == 0, "R9", long_pulse, 0);
        // R4 wrap
        preset(8'h20, 8'h00);
        wr(3'd5, 8'hF0, 1'b0);
        wr(3'd6, 8'h00, 1'b0);
        rd(3'd6, 8'h10, "R4 wrap");
        // R11 refresh on match cycle
        preset(8'h30, 8'hFF);
        wr(3'd5, 8'h01, 1'b0);
        wr(3'd6, 8'h00, 1'b0);
        base = rst_cnt;
        wr(3'd6, 8'h00, 1'b1);
        repeat (3) @(negedge clk);
        chk(rst_cnt == base, "R11", rst_cnt - base, 0);
        rd(3'd3, 8'h31, "R11");
        // R10 disable on match cycle
        preset(8'h40, 8'hFF);
        wr(3'd6, 8'h00, 1'b0);
        base = rst_cnt;
        wr(3'd1, 8'h00, 1'b1);
        repeat (3) @(negedge clk);
        chk(rst_cnt == base, "R10", rst_cnt - base, 0);
        ticks(4);
        rd(3'd2, 8'h00, "R10 stopped");
        wr(3'd3, 8'h55, 1'b0);
        rd(3'd3, 8'h55, "R10 unlocked");
        wr(3'd4, 8'h11, 1'b0);
        rd(3'd4, 8'h11, "R10 unlocked");
        // R10 disabled: match ignored, deadline stored directly
        wr(3'd0, 8'h01, 1'b0);
        wr(3'd2, 8'hFF, 1'b0);
        wr(3'd6, 8'h56, 1'b0);
        rd(3'd6, 8'h56, "R10");
        base = rst_cnt;
        ticks(1);
        repeat (3) @(negedge clk);
        chk(rst_cnt == base, "R10", rst_cnt - base, 0);
        // Re-enable takes effect next clock
        wr(3'd1, 8'h80, 1'b0);
        rd(3'd1, 8'h80, "R10 reenable");
        rd(3'd4, 8'h48, "R8");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                fails++; checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule